// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a ring of 16-byte transmit descriptors in system memory. Descriptors pass back and forth between host and hardware through an ownership flag in each control word. Software fills descriptors, hands them to hardware and writes a doorbell. The engine then reads descriptors one after another, starting at its current ring slot. For each hardware-owned descriptor it gives the buffer address and frame length to a downstream frame mover. When the mover reports completion, the engine writes the control word back with ownership returned to the host.

The scan ends at the first descriptor that the host still owns. A descriptor marked end-of-ring sends the walk back to the ring base. The current slot is kept between scans. Memory traffic uses a simple 32-bit word port with a ready handshake. Completion and ring-empty events come out as one-cycle status pulses, with bit positions that match an interrupt status layout.

Top module: `txr_engine`

## Requirements
- R1: While reset is held and afterwards until a doorbell arrives, `mem_req_o` and `frm_valid_o` are low and `sts_o` is zero.
- R2: A cycle with `poll_we_i` high and `poll_data_i[6]` set starts a scan at the current slot. A poll write with bit 6 clear produces no memory request.
- R3: For an owned descriptor the engine reads the control word at byte offset 0, the buffer address low word at offset 8 and the high word at offset 12. It does not read the word at offset 4. It presents `{high,low}` on `frm_addr_o` and control bits 15:0 on `frm_len_o`.
- R4: `frm_valid_o` stays high, with `frm_addr_o` and `frm_len_o` stable, until the cycle in which `frm_done_i` is high. No memory request is made during that time.
- R5: After the mover completes, the control word is written back to offset 0 with bit 31 (ownership) cleared and every other bit, including bit 30, unchanged. The write is followed by a one-cycle pulse on `sts_o[2]` (transmit OK).
- R6: A control word read with bit 31 clear ends the scan. That descriptor is not written. A one-cycle pulse appears on `sts_o[7]` (no descriptor available). At most one status bit is set in any cycle.
- R7: After a descriptor with bit 30 (end of ring) set, the next slot is the ring base. Otherwise the next slot is 16 bytes further on. The slot reached is kept across scans.
- R8: An owned descriptor that lacks bit 29 (first segment) or bit 28 (last segment) is not passed to the mover. It is written back with ownership cleared, followed by a pulse on `sts_o[3]` (transmit error).
- R9: Any number of doorbells that arrive while a scan is in progress cause exactly one further scan, which starts immediately after the current scan ends.
- R10: A memory request holds its address, direction and write data until `mem_ready_i` is high. Read data is taken in that same cycle.
- R11: A descriptor address is `{base_hi_i,base_lo_i} + 16*slot`, computed at 64 bits with the carry propagated into the high word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_lo_i | input | 32 | Ring base address, low word |
| base_hi_i | input | 32 | Ring base address, high word |
| poll_we_i | input | 1 | Poll register write strobe |
| poll_data_i | input | 8 | Poll register write data; bit 6 is the normal-queue doorbell |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 64 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ready_i | input | 1 | Memory accepts the request this cycle |
| mem_rdata_i | input | 32 | Memory read data, valid with `mem_ready_i` |
| frm_valid_o | output | 1 | Frame request to the mover |
| frm_addr_o | output | 64 | Frame buffer address |
| frm_len_o | output | 16 | Frame length in bytes |
| frm_done_i | input | 1 | Mover finished the frame |
| sts_o | output | 16 | One-cycle status pulses: bit 2 OK, bit 3 error, bit 7 ring empty |

## Verification
The assertions check on every cycle that requests and frame offers are held stable until accepted, that memory is idle while a frame is out, and that at most one status pulse occurs per cycle. They also check that each OK pulse follows an accepted write and each empty pulse follows an accepted read of an unowned control word. Only the bench scenarios can show the ring order: the end-of-ring wrap, the carry across the 64-bit base, the slot kept between scans, the segment-flag errors, the single rescan after doorbells during a scan, and the exact words written back. The bench shows these by comparing every memory transaction, frame offer and status pulse with a behavioural ring walk.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int DW       = 32;
  localparam int AW       = 2 * DW;
  localparam int LEN_W    = 16;
  localparam int STS_W    = 16;
  localparam int DB_BIT   = 6;
  // control word flags
  localparam int C_OWN    = 31;
  localparam int C_EOR    = 30;
  localparam int C_FS     = 29;
  localparam int C_LS     = 28;
  // status pulse positions
  localparam int S_TOK    = 2;
  localparam int S_TER    = 3;
  localparam int S_TDU    = 7;
  // word offsets inside a descriptor
  localparam logic [1:0] W_CTL = 2'd0;
  localparam logic [1:0] W_ALO = 2'd2;
  localparam logic [1:0] W_AHI = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CTL, ST_ALO, ST_AHI, ST_XFER, ST_WB
  } txr_state_e;
endpackage

// File: rtl/txr_doorbell.sv
module txr_doorbell
  import txr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       poll_we_i,
  input  logic [7:0] poll_data_i,
  input  logic       ack_i,
  output logic       start_o
);
  logic db_now, pend_q;

  assign db_now  = poll_we_i & poll_data_i[DB_BIT];
  assign start_o = db_now | pend_q;

  // collapses any number of rings into one pending scan
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= 1'b0;
    else if (ack_i) pend_q <= 1'b0;
    else if (db_now) pend_q <= 1'b1;
  end
endmodule

// File: rtl/txr_addr_gen.sv
module txr_addr_gen
  import txr_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic [DW-1:0]    base_lo_i,
  input  logic [DW-1:0]    base_hi_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [1:0]       woff_i,
  output logic [AW-1:0]    addr_o
);
  localparam int SLOT_SH = 4;
  logic [AW-1:0] base, slot, word;

  assign base   = {base_hi_i, base_lo_i};
  assign slot   = AW'(idx_i) << SLOT_SH;
  assign word   = AW'(woff_i) << 2;
  assign addr_o = base + slot + word;
endmodule

// File: rtl/txr_seq.sv
module txr_seq
  import txr_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             ack_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [1:0]       woff_o,
  output logic [DW-1:0]    wdata_o,
  input  logic             mem_ready_i,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             frm_valid_o,
  output logic [AW-1:0]    frm_addr_o,
  output logic [LEN_W-1:0] frm_len_o,
  input  logic             frm_done_i,
  output logic [STS_W-1:0] sts_o
);
  txr_state_e st_q, st_d;
  logic [DW-1:0]    ctl_q, alo_q, ahi_q;
  logic [IDX_W-1:0] idx_q;
  logic [STS_W-1:0] sts_d, sts_q;
  logic             seg_ok;

  assign seg_ok = ctl_q[C_FS] & ctl_q[C_LS];

  always_comb begin
    st_d  = st_q;
    ack_o = 1'b0;
    sts_d = '0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin st_d = ST_CTL; ack_o = 1'b1; end
      ST_CTL: if (mem_ready_i) begin
        if (!mem_rdata_i[C_OWN]) begin
          sts_d[S_TDU] = 1'b1;
          if (start_i) ack_o = 1'b1;
          else         st_d  = ST_IDLE;
        end else st_d = ST_ALO;
      end
      ST_ALO: if (mem_ready_i) st_d = ST_AHI;
      ST_AHI: if (mem_ready_i) st_d = seg_ok ? ST_XFER : ST_WB;
      ST_XFER: if (frm_done_i) st_d = ST_WB;
      ST_WB: if (mem_ready_i) begin
        st_d = ST_CTL;
        if (seg_ok) sts_d[S_TOK] = 1'b1;
        else        sts_d[S_TER] = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      ctl_q <= '0;
      alo_q <= '0;
      ahi_q <= '0;
      idx_q <= '0;
      sts_q <= '0;
    end else begin
      st_q  <= st_d;
      sts_q <= sts_d;
      if (mem_ready_i) begin
        if (st_q == ST_CTL) ctl_q <= mem_rdata_i;
        if (st_q == ST_ALO) alo_q <= mem_rdata_i;
        if (st_q == ST_AHI) ahi_q <= mem_rdata_i;
        if (st_q == ST_WB)  idx_q <= ctl_q[C_EOR] ? '0 : idx_q + 1'b1;
      end
    end
  end

  always_comb begin
    mem_req_o = 1'b0;
    mem_we_o  = 1'b0;
    woff_o    = W_CTL;
    unique case (st_q)
      ST_CTL:  mem_req_o = 1'b1;
      ST_ALO:  begin mem_req_o = 1'b1; woff_o = W_ALO; end
      ST_AHI:  begin mem_req_o = 1'b1; woff_o = W_AHI; end
      ST_WB:   begin mem_req_o = 1'b1; mem_we_o = 1'b1; end
      default: ;
    endcase
  end

  assign wdata_o     = {1'b0, ctl_q[DW-2:0]};
  assign idx_o       = idx_q;
  assign frm_valid_o = (st_q == ST_XFER);
  assign frm_addr_o  = {ahi_q, alo_q};
  assign frm_len_o   = ctl_q[LEN_W-1:0];
  assign sts_o       = sts_q;
endmodule

// File: rtl/txr_engine.sv
module txr_engine
  import txr_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [31:0]      base_lo_i,
  input  logic [31:0]      base_hi_i,
  input  logic             poll_we_i,
  input  logic [7:0]       poll_data_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [63:0]      mem_addr_o,
  output logic [31:0]      mem_wdata_o,
  input  logic             mem_ready_i,
  input  logic [31:0]      mem_rdata_i,
  output logic             frm_valid_o,
  output logic [63:0]      frm_addr_o,
  output logic [15:0]      frm_len_o,
  input  logic             frm_done_i,
  output logic [15:0]      sts_o
);
  logic             start, ack;
  logic [1:0]       woff;
  logic [IDX_W-1:0] idx;

  txr_doorbell u_db (
    .clk_i, .rst_ni, .poll_we_i, .poll_data_i,
    .ack_i(ack), .start_o(start)
  );

  txr_seq #(.IDX_W(IDX_W)) u_seq (
    .clk_i, .rst_ni,
    .start_i(start), .ack_o(ack),
    .mem_req_o, .mem_we_o, .woff_o(woff), .wdata_o(mem_wdata_o),
    .mem_ready_i, .mem_rdata_i,
    .idx_o(idx),
    .frm_valid_o, .frm_addr_o, .frm_len_o, .frm_done_i,
    .sts_o
  );

  txr_addr_gen #(.IDX_W(IDX_W)) u_ag (
    .base_lo_i, .base_hi_i, .idx_i(idx), .woff_i(woff), .addr_o(mem_addr_o)
  );
endmodule

// File: rtl/txr_engine_chk.sv
module txr_engine_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [63:0] mem_addr_o,
  input logic [31:0] mem_wdata_o,
  input logic        mem_ready_i,
  input logic [31:0] mem_rdata_i,
  input logic        frm_valid_o,
  input logic [63:0] frm_addr_o,
  input logic [15:0] frm_len_o,
  input logic        frm_done_i,
  input logic [15:0] sts_o
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)); // R10
  AST_FRM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid_o && !frm_done_i |=> frm_valid_o && $stable(frm_addr_o) && $stable(frm_len_o)); // R4
  AST_FRM_MEM_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid_o |-> !mem_req_o); // R4
  AST_TOK_AFTER_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_o[2] |-> $past(mem_req_o && mem_we_o && mem_ready_i)); // R5
  AST_TDU_AFTER_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_o[7] |-> $past(mem_req_o && !mem_we_o && mem_ready_i && !mem_rdata_i[31])); // R6
  AST_STS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sts_o)); // R6
endmodule

bind txr_engine txr_engine_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i),
  .frm_valid_o(frm_valid_o), .frm_addr_o(frm_addr_o), .frm_len_o(frm_len_o),
  .frm_done_i(frm_done_i), .sts_o(sts_o)
);

// File: tb/txr_engine_test.sv
module txr_engine_test;
  localparam int  CLK_PERIOD = 10;
  localparam logic [63:0] BASE = 64'h0000_0002_FFFF_FFC0;
  localparam int  NW = 64;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        poll_we = 1'b0;
  logic [7:0]  poll_data = '0;
  logic        mem_req, mem_we, mem_ready = 1'b0, frm_valid, frm_done = 1'b0;
  logic [63:0] mem_addr, frm_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;
  logic [15:0] frm_len, sts;

  txr_engine uut (
    .clk_i(clk), .rst_ni(rst_n),
    .base_lo_i(BASE[31:0]), .base_hi_i(BASE[63:32]),
    .poll_we_i(poll_we), .poll_data_i(poll_data),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata),
    .frm_valid_o(frm_valid), .frm_addr_o(frm_addr), .frm_len_o(frm_len),
    .frm_done_i(frm_done), .sts_o(sts)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] mem [NW];   // memory seen by the engine
  logic [31:0] mm  [NW];   // reference model's copy
  int midx = 0;            // model ring slot

  logic [63:0] ea_q[$]; logic ew_q[$]; logic [31:0] ed_q[$];
  logic [63:0] fa_q[$]; logic [15:0] fl_q[$];
  logic [15:0] es_q[$];

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit stall = 0; int frm_delay = 0, frm_cnt = 0; bit frm_seen = 0;
  logic [63:0] frm_a0; logic [15:0] frm_l0;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_desc(int i, logic [31:0] c, logic [31:0] lo, logic [31:0] hi);
    mem[4*i] = c; mem[4*i+1] = 32'hA5A5_0000 | i; mem[4*i+2] = lo; mem[4*i+3] = hi;
    for (int k = 0; k < 4; k++) mm[4*i+k] = mem[4*i+k];
  endtask

  // behavioural ring walk producing the expected event streams
  task automatic predict(int scans);
    for (int s = 0; s < scans; s++) begin
      for (int g = 0; g < 32; g++) begin
        logic [63:0] a; logic [31:0] c;
        a = BASE + 64'(midx) * 16;
        c = mm[4*midx];
        ea_q.push_back(a); ew_q.push_back(0); ed_q.push_back('0);
        if (!c[31]) begin es_q.push_back(16'h0080); break; end
        ea_q.push_back(a + 8);  ew_q.push_back(0); ed_q.push_back('0);
        ea_q.push_back(a + 12); ew_q.push_back(0); ed_q.push_back('0);
        if (c[29] && c[28]) begin
          fa_q.push_back({mm[4*midx+3], mm[4*midx+2]}); fl_q.push_back(c[15:0]);
        end
        c[31] = 1'b0;
        ea_q.push_back(a); ew_q.push_back(1); ed_q.push_back(c);
        es_q.push_back((mm[4*midx][29] && mm[4*midx][28]) ? 16'h0004 : 16'h0008);
        mm[4*midx] = c;
        midx = c[30] ? 0 : midx + 1;
      end
    end
  endtask

  task automatic ring(logic [7:0] d);
    @(negedge clk); poll_we = 1'b1; poll_data = d;
    @(negedge clk); poll_we = 1'b0; poll_data = '0;
  endtask

  task automatic wait_quiet();
    while (ea_q.size() || fa_q.size() || es_q.size()) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  task automatic mem_match(string req);
    int bad = 0;
    for (int k = 0; k < NW; k++) if (mem[k] !== mm[k]) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  // responders and monitors, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      mem_ready = 1'b0; frm_done = 1'b0; frm_seen = 1'b0;
    end else begin
      if (sts !== 16'h0) begin
        if (es_q.size() == 0) chk(0, "R6", sts, 0);
        else begin
          logic [15:0] e; e = es_q.pop_front();
          chk(sts === e, e == 16'h0004 ? "R5" : (e == 16'h0008 ? "R8" : "R6"), sts, e);
        end
      end
      mem_ready = stall ? (cyc % 3 != 1) : 1'b1;
      if (mem_req && mem_ready) begin
        logic [63:0] off; int wi;
        off = mem_addr - BASE;
        wi  = int'(off[7:0]) >> 2;
        chk(off < 64'd256, "R11", mem_addr, BASE);
        if (ea_q.size() == 0) chk(0, "R2", mem_addr, 0);
        else begin
          logic [63:0] ea; logic ew; logic [31:0] ed;
          ea = ea_q.pop_front(); ew = ew_q.pop_front(); ed = ed_q.pop_front();
          chk(mem_addr === ea && mem_we === ew, stall ? "R10" : "R7", {mem_addr[62:0], mem_we}, {ea[62:0], ew});
          if (ew) chk(mem_wdata === ed, "R5", mem_wdata, ed);
        end
        if (off < 64'd256) begin
          if (mem_we) mem[wi] = mem_wdata;
          else        mem_rdata = mem[wi];
        end
      end
      if (frm_valid) begin
        if (!frm_seen) begin
          frm_seen = 1'b1; frm_cnt = frm_delay; frm_a0 = frm_addr; frm_l0 = frm_len;
          if (fa_q.size() == 0) chk(0, "R8", frm_addr, 0);
          else begin
            logic [63:0] fa; logic [15:0] fl;
            fa = fa_q.pop_front(); fl = fl_q.pop_front();
            chk(frm_addr === fa && frm_len === fl, "R3", {frm_addr[47:0], frm_len}, {fa[47:0], fl});
          end
        end
        if (frm_cnt == 0) begin
          frm_done = 1'b1;
          chk(frm_addr === frm_a0 && frm_len === frm_l0, "R4", frm_addr, frm_a0);
        end else frm_cnt--;
      end else begin
        frm_seen = 1'b0; frm_done = 1'b0;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NW; k++) begin mem[k] = '0; mm[k] = '0; end
    repeat (3) @(negedge clk);
    chk(mem_req === 1'b0 && frm_valid === 1'b0 && sts === 16'h0, "R1", {mem_req, frm_valid, sts}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(mem_req === 1'b0 && frm_valid === 1'b0 && sts === 16'h0, "R1", {mem_req, frm_valid, sts}, 0);

    // two good frames, stop at slot 2
    set_desc(0, 32'hB000_003C, 32'h1234_5670, 32'h0000_0001);
    set_desc(1, 32'hB000_05EA, 32'h89AB_CDE0, 32'h0000_0003);
    set_desc(2, 32'h3000_0040, 32'h0, 32'h0);
    frm_delay = 3;
    predict(1); ring(8'h40); wait_quiet();
    mem_match("R5");

    // poll write without the normal-queue bit
    ring(8'h81);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (mem_req !== 1'b0) begin chk(0, "R2", mem_req, 0); break; end
    end
    chk(mem_req === 1'b0 && ea_q.size() == 0, "R2", mem_req, 0);

    // wrap on end-of-ring, crossing the low-word carry, with memory stalls
    stall = 1; frm_delay = 0;
    set_desc(2, 32'hB000_0100, 32'h0000_2000, 32'h0);
    set_desc(3, 32'hB000_0101, 32'h0000_3000, 32'h0);
    set_desc(4, 32'hB000_0102, 32'h0000_4000, 32'h0);
    set_desc(5, 32'hF000_0103, 32'h0000_5000, 32'h0);
    set_desc(0, 32'hB000_0104, 32'h0000_6000, 32'h0);
    predict(1); ring(8'h40); wait_quiet();
    mem_match("R7");
    chk(mem[20] === 32'h7000_0103, "R11", mem[20], 32'h7000_0103);
    stall = 0;

    // segment flag errors
    set_desc(1, 32'hA000_0010, 32'h0000_7000, 32'h0);
    set_desc(2, 32'h9000_0011, 32'h0000_8000, 32'h0);
    set_desc(3, 32'hB000_0012, 32'h0000_9000, 32'h0);
    set_desc(4, 32'h0000_0000, 32'h0, 32'h0);
    predict(1); ring(8'h40); wait_quiet();
    mem_match("R8");

    // doorbells during a scan give exactly one rescan
    frm_delay = 12;
    set_desc(4, 32'hB000_0200, 32'h0000_A000, 32'h0);
    predict(2); ring(8'h40);
    while (!frm_valid) @(negedge clk);
    ring(8'h40); ring(8'hC0);
    wait_quiet();
    chk(ea_q.size() == 0 && es_q.size() == 0, "R9", es_q.size(), 0);
    mem_match("R9");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule